// File: doc/BRIEF.md
# Half-Bridge Dead-Time Pulse Generator

This block produces the two gate requests for a half-bridge power stage from a self-running digital timebase. The timebase alternates between a charge phase, whose length comes from a charge-period word, and a discharge phase of fixed length. The discharge phase is the dead time, so the two gate requests are always separated by it. Each time a discharge phase completes, a side flip-flop toggles. The flip-flop steers the next charge phase to the low-side request or to the high-side request. Each output therefore switches at half the timebase rate, and both sides see the same pulse width.

A run input gates the whole block. While run is low the timebase is held in its idle state, both requests stay low and the side flip-flop is preset to the low side. Because of this preset, the low side always delivers the first pulse after any restart, which charges a bootstrap supply before the high side is driven. A one-bit select picks a long or a short dead time. With the default parameters and a 50 MHz clock, the long dead time is 600 ns and the short one is 300 ns. A charge word of about 1000 cycles gives roughly 25 kHz per output, and about 37 cycles gives roughly 480 kHz.

The timebase state machine has three states:
- `TB_IDLE`: stopped.
- `TB_CHARGE`: the counter counts up while one gate request is driven.
- `TB_DISCHARGE`: the counter counts down while both requests are low.

Its transitions are:
- idle to charge, when run is high (restart);
- charge to discharge, at the last charge cycle;
- discharge to charge, when the down-count reaches zero (wrap);
- any state to idle, when run is low.

Top module: `hb_pulse_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released with `run` still low, `gate_lo`, `gate_hi` and `cycle_done` are 0.
- R2: While `run` is low, the timebase is stopped and all three outputs are 0. If `run` is sampled low at a clock edge, all outputs are 0 after that edge, even in the middle of a pulse.
- R3: The first clock edge at which `run` is sampled high, coming from the idle state, starts a charge phase. A charge phase drives its gate request high for exactly `chg_word` cycles.
- R4: Between two consecutive gate pulses, both requests are low for exactly 30 cycles when `dead_sel` is 0 and exactly 15 cycles when `dead_sel` is 1.
- R5: Gate pulses alternate low side, high side, low side, and so on. Both sides use the same charge-length rule, so one output period is two charge lengths plus two dead times.
- R6: After every restart the first pulse is on `gate_lo`. It rises at the first edge where `run` is sampled high.
- R7: `chg_word` is sampled only at the edge that starts a charge phase. Changing it during a pulse or a dead time affects only later pulses.
- R8: `dead_sel` is sampled only at the edge that starts a discharge phase. Changing it during a dead time does not alter that dead time.
- R9: `gate_lo` and `gate_hi` are never high in the same cycle.
- R10: `cycle_done` is high for exactly one cycle: the first cycle of each charge phase that follows a completed dead time. It is not high on the first pulse after a restart.
- R11: A `chg_word` of 0 is treated as 1, giving a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Run enable; low stops the timebase and presets the low side |
| chg_word | input | CHG_W | Charge length in clock cycles (0 treated as 1) |
| dead_sel | input | 1 | Dead-time select: 0 long, 1 short |
| gate_lo | output | 1 | Low-side gate request |
| gate_hi | output | 1 | High-side gate request |
| cycle_done | output | 1 | One-cycle strobe at the start of each charge after a dead time |

## Verification
The assertions check on every cycle that:
- the two gate requests never overlap;
- every rising gate edge is preceded by a cycle with both requests low;
- the high side never pulses before the low side has pulsed since the last restart;
- a low `run` clears all outputs at the next edge;
- `cycle_done` coincides with exactly one active request and follows a dead cycle.

The exact pulse widths and dead-time lengths can only be shown by the bench's scenarios and its cycle model. The same holds for the points at which `chg_word` and `dead_sel` are sampled, and for the one-cycle pulse from a zero word.

// File: rtl/hb_pulse_pkg.sv
package hb_pulse_pkg;

    typedef enum logic [1:0] {
        TB_IDLE      = 2'd0,
        TB_CHARGE    = 2'd1,
        TB_DISCHARGE = 2'd2
    } tb_state_e;

    typedef enum logic {
        SIDE_LOW  = 1'b0,
        SIDE_HIGH = 1'b1
    } side_e;

endpackage

// File: rtl/hb_timebase.sv
module hb_timebase
    import hb_pulse_pkg::*;
#(
    parameter int CHG_W          = 11,
    parameter int DEAD_LONG_CYC  = 30,
    parameter int DEAD_SHORT_CYC = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CHG_W-1:0] chg_word,
    input  logic             dead_sel,
    output tb_state_e        state_nxt,
    output logic             wrap
);
    localparam int DEAD_MAX = (DEAD_LONG_CYC > DEAD_SHORT_CYC) ? DEAD_LONG_CYC : DEAD_SHORT_CYC;
    localparam int DEAD_W   = $clog2(DEAD_MAX + 1);
    localparam int CNT_W    = (CHG_W > DEAD_W) ? CHG_W : DEAD_W;
    localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(DEAD_LONG_CYC - 1);
    localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(DEAD_SHORT_CYC - 1);

    tb_state_e        state_q;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CHG_W-1:0] per_q, per_d;
    logic [CHG_W-1:0] per_load;
    logic [CNT_W-1:0] dead_load;
    logic             charge_last;

    // zero word clamps to a single-cycle charge (R11)
    assign per_load    = (chg_word == '0) ? CHG_W'(1) : chg_word;
    assign dead_load   = dead_sel ? SHORT_LOAD : LONG_LOAD;
    assign charge_last = (cnt_q == (CNT_W'(per_q) - CNT_W'(1)));

    // next-state and counter logic
    always_comb begin
        state_nxt = state_q;
        cnt_d     = cnt_q;
        per_d     = per_q;
        wrap      = 1'b0;
        unique case (state_q)
            TB_IDLE: begin
                cnt_d = '0;
                if (run) begin
                    state_nxt = TB_CHARGE;
                    per_d     = per_load;
                end
            end
            TB_CHARGE: begin
                if (!run) begin
                    state_nxt = TB_IDLE;
                    cnt_d     = '0;
                end else if (charge_last) begin
                    state_nxt = TB_DISCHARGE;
                    cnt_d     = dead_load;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            TB_DISCHARGE: begin
                if (!run) begin
                    state_nxt = TB_IDLE;
                    cnt_d     = '0;
                end else if (cnt_q == '0) begin
                    state_nxt = TB_CHARGE;
                    per_d     = per_load;
                    wrap      = 1'b1;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: begin
                state_nxt = TB_IDLE;
                cnt_d     = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TB_IDLE;
            cnt_q   <= '0;
            per_q   <= CHG_W'(1);
        end else begin
            state_q <= state_nxt;
            cnt_q   <= cnt_d;
            per_q   <= per_d;
        end
    end

endmodule

// File: rtl/hb_side_toggle.sv
module hb_side_toggle
    import hb_pulse_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  logic  wrap,
    output side_e side_nxt
);
    side_e side_q;

    // preset to low side while stopped (R6); toggle on each wrap (R5)
    always_comb begin
        if (!run)
            side_nxt = SIDE_LOW;
        else if (wrap)
            side_nxt = (side_q == SIDE_LOW) ? SIDE_HIGH : SIDE_LOW;
        else
            side_nxt = side_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            side_q <= SIDE_LOW;
        else
            side_q <= side_nxt;
    end

endmodule

// File: rtl/hb_gate_stage.sv
module hb_gate_stage
    import hb_pulse_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  tb_state_e state_nxt,
    input  side_e     side_nxt,
    input  logic      wrap,
    output logic      gate_lo,
    output logic      gate_hi,
    output logic      cycle_done
);
    // registered outputs, decoded from the next state and next side
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_lo    <= 1'b0;
            gate_hi    <= 1'b0;
            cycle_done <= 1'b0;
        end else begin
            gate_lo    <= (state_nxt == TB_CHARGE) && (side_nxt == SIDE_LOW);
            gate_hi    <= (state_nxt == TB_CHARGE) && (side_nxt == SIDE_HIGH);
            cycle_done <= wrap;
        end
    end

endmodule

// File: rtl/hb_pulse_gen.sv
module hb_pulse_gen
    import hb_pulse_pkg::*;
#(
    parameter int CHG_W          = 11,
    parameter int DEAD_LONG_CYC  = 30,
    parameter int DEAD_SHORT_CYC = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CHG_W-1:0] chg_word,
    input  logic             dead_sel,
    output logic             gate_lo,
    output logic             gate_hi,
    output logic             cycle_done
);
    tb_state_e state_nxt;
    side_e     side_nxt;
    logic      wrap;

    hb_timebase #(
        .CHG_W          (CHG_W),
        .DEAD_LONG_CYC  (DEAD_LONG_CYC),
        .DEAD_SHORT_CYC (DEAD_SHORT_CYC)
    ) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .chg_word  (chg_word),
        .dead_sel  (dead_sel),
        .state_nxt (state_nxt),
        .wrap      (wrap)
    );

    hb_side_toggle u_side (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .wrap     (wrap),
        .side_nxt (side_nxt)
    );

    hb_gate_stage u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_nxt  (state_nxt),
        .side_nxt   (side_nxt),
        .wrap       (wrap),
        .gate_lo    (gate_lo),
        .gate_hi    (gate_hi),
        .cycle_done (cycle_done)
    );

endmodule

// File: rtl/hb_pulse_gen_chk.sv
module hb_pulse_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic gate_lo,
    input logic gate_hi,
    input logic cycle_done
);
    logic lo_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lo_seen <= 1'b0;
        else if (!run)
            lo_seen <= 1'b0;
        else if (gate_lo)
            lo_seen <= 1'b1;
    end

    a_r9_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_lo && gate_hi));

    a_r2_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!gate_lo && !gate_hi && !cycle_done));

    a_r6_low_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> lo_seen);

    a_r4_gap_before_hi: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> $past(!gate_lo && !gate_hi));

    a_r4_gap_before_lo: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_lo) && cycle_done) |-> $past(!gate_lo && !gate_hi));

    a_r10_done_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> ($countones({gate_lo, gate_hi}) == 1));

    a_r10_done_after_dead: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> $past(!gate_lo && !gate_hi));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !cycle_done);

endmodule

bind hb_pulse_gen hb_pulse_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .gate_lo    (gate_lo),
    .gate_hi    (gate_hi),
    .cycle_done (cycle_done)
);

// File: tb/hb_pulse_gen_test.sv
`timescale 1ns/1ps
module hb_pulse_gen_test;
    localparam int CW         = 11;
    localparam int DEAD_LONG  = 30;
    localparam int DEAD_SHORT = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic [CW-1:0] chg_word = CW'(40);
    logic          dead_sel = 1'b0;
    logic          gate_lo, gate_hi, cycle_done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    hb_pulse_gen uut (
        .clk(clk), .rst_n(rst_n), .run(run), .chg_word(chg_word),
        .dead_sel(dead_sel), .gate_lo(gate_lo), .gate_hi(gate_hi),
        .cycle_done(cycle_done)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // behavioural reference: remaining-cycle counter per phase
    int m_active = 0, m_charge = 0, m_rem = 0, m_side = 0;
    int m_lo = 0, m_hi = 0, m_done = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_active = 0; m_charge = 0; m_rem = 0; m_side = 0;
            m_lo = 0; m_hi = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (!run) begin
                m_active = 0; m_charge = 0; m_side = 0; m_rem = 0;
            end else if (m_active == 0) begin
                m_active = 1; m_charge = 1; m_side = 0;
                m_rem = (chg_word == 0) ? 1 : int'(chg_word);
            end else if (m_charge == 1) begin
                m_rem--;
                if (m_rem == 0) begin
                    m_charge = 0;
                    m_rem = dead_sel ? DEAD_SHORT : DEAD_LONG;
                end
            end else begin
                m_rem--;
                if (m_rem == 0) begin
                    m_charge = 1;
                    m_side = 1 - m_side;
                    m_rem = (chg_word == 0) ? 1 : int'(chg_word);
                    m_done = 1;
                end
            end
            m_lo = (m_active == 1 && m_charge == 1 && m_side == 0) ? 1 : 0;
            m_hi = (m_active == 1 && m_charge == 1 && m_side == 1) ? 1 : 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R5 model gate_lo", int'(gate_lo), m_lo);
            check("R5 model gate_hi", int'(gate_hi), m_hi);
            check("R10 model cycle_done", int'(cycle_done), m_done);
            check("R9 overlap", int'(gate_lo && gate_hi), 0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic bit both_low();
        return !gate_lo && !gate_hi;
    endfunction

    task automatic width_lo(output int n);
        n = 0;
        while (gate_lo) begin n++; @(negedge clk); end
    endtask

    task automatic width_hi(output int n);
        n = 0;
        while (gate_hi) begin n++; @(negedge clk); end
    endtask

    task automatic width_gap(output int n);
        n = 0;
        while (both_low()) begin n++; @(negedge clk); end
    endtask

    initial begin
        int n;
        int g;
        repeat (3) @(negedge clk);
        check("R1 reset lo", int'(gate_lo), 0);
        check("R1 reset hi", int'(gate_hi), 0);
        check("R1 reset done", int'(cycle_done), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 idle after reset", int'(gate_lo | gate_hi | cycle_done), 0);

        run = 1'b1;
        @(negedge clk);
        check("R6 first pulse low side", int'(gate_lo), 1);
        check("R10 no strobe at restart", int'(cycle_done), 0);
        width_lo(n);   check("R3 low pulse width", n, 40);
        width_gap(n);  check("R4 long dead time", n, DEAD_LONG);
        check("R5 high side follows", int'(gate_hi), 1);
        check("R10 strobe at charge start", int'(cycle_done), 1);
        width_hi(n);   check("R5 high pulse width", n, 40);
        width_gap(n);  check("R4 long dead time again", n, DEAD_LONG);
        check("R5 low side returns", int'(gate_lo), 1);

        dead_sel = 1'b1;
        repeat (3) @(negedge clk);
        chg_word = CW'(20);
        width_lo(n);   check("R7 pulse kept old word", n + 3, 40);
        width_gap(n);  check("R4 short dead time", n, DEAD_SHORT);
        width_hi(n);   check("R7 new word applied", n, 20);
        g = 0;
        repeat (5) begin g++; @(negedge clk); end
        dead_sel = 1'b0;
        width_gap(n);  check("R8 dead time unchanged by select", g + n, DEAD_SHORT);
        width_lo(n);   check("R7 low width new word", n, 20);
        width_gap(n);  check("R8 new select used next", n, DEAD_LONG);

        repeat (4) @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        check("R2 run drop clears outputs", int'(gate_lo | gate_hi | cycle_done), 0);
        repeat (20) @(negedge clk);
        check("R2 stays stopped", int'(gate_lo | gate_hi | cycle_done), 0);

        run = 1'b1;
        @(negedge clk);
        check("R6 low side first after restart", int'(gate_lo), 1);
        check("R6 high side idle after restart", int'(gate_hi), 0);
        chg_word = '0;
        width_lo(n);   check("R3 restart pulse width", n, 20);
        width_gap(n);  check("R4 dead after restart", n, DEAD_LONG);
        width_hi(n);   check("R11 zero word one cycle", n, 1);
        width_gap(n);  check("R4 dead after short pulse", n, DEAD_LONG);
        width_lo(n);   check("R11 zero word low side", n, 1);

        repeat (10) @(negedge clk);
        run = 1'b0;
        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule